// File: doc/BRIEF.md
# Priority Conversion Trigger Arbiter

This block decides when a high-priority analog-to-digital conversion begins and which analog channel it samples. Three start sources feed it: a one-cycle software start strobe, a timer trigger line and an external trigger pin. The two asynchronous lines pass through a two-flop synchronizer followed by an edge detector. A detected start becomes a pending request at one of two priority levels. The external pin is level 1, the urgent level. Software and timer starts share level 2.

When the converter is idle, the arbiter grants one level. It emits a single-cycle start pulse together with a 5-bit channel number and a 3-bit one-hot start-factor code, which the result path stores beside the converted value. A level-2 start takes its channel from a 5-bit configuration field. A level-1 start uses 3 bits only, so it reaches channels 0 to 7. Those 3 bits come either from a configuration field or from three select pins, as chosen by a held selection bit. Writes to that bit are refused while a conversion is underway.

The controller has three states. IDLE grants when a request is pending and the converter busy flag is low (transition IDLE->LAUNCH). LAUNCH drives the start pulse for one cycle and always moves on (LAUNCH->CONVERT). CONVERT waits for the busy flag to fall (CONVERT->IDLE).

Top module: `prio_conv_arbiter`

## Requirements
- R1: `start_pulse` is high for exactly one cycle per grant. No grant is made in any cycle in which `conv_busy` is high or the controller is not in IDLE.
- R2: A falling edge on `ext_trig_pin` creates a level-1 request only while `ext_start_en` is 1. A rising edge creates none. Its grant carries `start_factor` = 3'b100.
- R3: A rising edge on `tmr_trig` creates a level-2 request only while `tmr_start_en` is 1. Its grant carries `start_factor` = 3'b010.
- R4: A high `sw_start_wr` cycle creates a level-2 request whatever the value of `tmr_start_en`. Its grant carries `start_factor` = 3'b001.
- R5: If software and timer requests are both pending when level 2 is granted, one conversion starts with `start_factor` = 3'b011.
- R6: When level-1 and level-2 requests are both pending at a grant, level 1 is granted first. The level-2 request is kept and granted once `conv_busy` has cleared.
- R7: A level-2 grant drives `start_chan` with `l2_chan_cfg` (any of 0 to 31).
- R8: A level-1 grant drives `start_chan[2:0]` from `l1_chan_cfg` when `ext_sel_q` is 0, and from `ext_chan_pins` when it is 1. `start_chan[4:3]` is 0 in both cases.
- R9: A `sel_wr` pulse loads `sel_wdata` into `ext_sel_q` only when the controller is in IDLE and `conv_busy` is low. Otherwise the write is ignored.
- R10: Latency is fixed by the synchronizer. For a trigger-pin or timer edge applied before clock edge k, the pulse appears after edge k+3. For a software strobe sampled at edge k, the pulse appears after edge k+1.
- R11: After reset, `start_pulse`, `start_chan`, `start_factor` and `ext_sel_q` are all 0. No request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start_wr | input | 1 | Software start write strobe |
| tmr_trig | input | 1 | Timer trigger line (asynchronous) |
| ext_trig_pin | input | 1 | External trigger pin, idle high (asynchronous) |
| ext_start_en | input | 1 | Enables external-pin starts |
| tmr_start_en | input | 1 | Enables timer starts |
| sel_wr | input | 1 | Write strobe for the level-1 channel source bit |
| sel_wdata | input | 1 | Value for the level-1 channel source bit |
| l1_chan_cfg | input | 3 | Level-1 channel field |
| l2_chan_cfg | input | 5 | Level-2 channel field |
| ext_chan_pins | input | 3 | Level-1 channel select pins |
| conv_busy | input | 1 | Converter busy flag |
| start_pulse | output | 1 | One-cycle conversion start |
| start_chan | output | 5 | Channel of the granted start |
| start_factor | output | 3 | One-hot start cause (001 software, 010 timer, 100 external) |
| ext_sel_q | output | 1 | Held level-1 channel source bit (1 = pins) |

## Verification
The arbiter is tried with each source in isolation to separate the three factor codes. Each source is also tried with its enable low, and the trigger pin's wrong edge is applied, to show that disabled or wrong-polarity edges start nothing. A software strobe aligned with a synchronized timer edge tells a merged 3'b011 grant apart from two separate conversions. Both levels are then raised under a held busy flag, which separates correct level-1-first ordering and level-2 retention from loss or reordering. Select-bit writes made during and after a conversion, and cycle-exact latency probes, complete the set.

// File: rtl/pca_pkg.sv
package pca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_CONVERT = 2'd2
    } arb_state_t;

    localparam logic [2:0] FAC_SW  = 3'b001;
    localparam logic [2:0] FAC_TMR = 3'b010;
    localparam logic [2:0] FAC_EXT = 3'b100;
endpackage

// File: rtl/pca_edge_sync.sv
module pca_edge_sync #(
    parameter int STAGES      = 2,
    parameter bit IDLE_LVL    = 1'b0,
    parameter bit DETECT_FALL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_pulse
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {DEPTH{IDLE_LVL}};
        else        shreg <= {shreg[DEPTH-2:0], async_in};
    end

    generate
        if (DETECT_FALL) begin : g_fall
            assign edge_pulse = ~shreg[STAGES-1] & shreg[STAGES];
        end else begin : g_rise
            assign edge_pulse = shreg[STAGES-1] & ~shreg[STAGES];
        end
    endgenerate
endmodule

// File: rtl/pca_chan_mux.sv
module pca_chan_mux #(
    parameter int CHAN_W = 5,
    parameter int L1_W   = 3
) (
    input  logic              use_l1,
    input  logic              use_pins,
    input  logic [L1_W-1:0]   l1_cfg,
    input  logic [L1_W-1:0]   pins,
    input  logic [CHAN_W-1:0] l2_cfg,
    output logic [CHAN_W-1:0] chan
);
    logic [L1_W-1:0] l1_pick;

    always_comb begin
        l1_pick = use_pins ? pins : l1_cfg;
        chan    = use_l1 ? CHAN_W'(l1_pick) : l2_cfg;
    end
endmodule

// File: rtl/prio_conv_arbiter.sv
module prio_conv_arbiter
    import pca_pkg::*;
#(
    parameter int CHAN_W      = 5,
    parameter int L1_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start_wr,
    input  logic              tmr_trig,
    input  logic              ext_trig_pin,
    input  logic              ext_start_en,
    input  logic              tmr_start_en,
    input  logic              sel_wr,
    input  logic              sel_wdata,
    input  logic [L1_W-1:0]   l1_chan_cfg,
    input  logic [CHAN_W-1:0] l2_chan_cfg,
    input  logic [L1_W-1:0]   ext_chan_pins,
    input  logic              conv_busy,
    output logic              start_pulse,
    output logic [CHAN_W-1:0] start_chan,
    output logic [2:0]        start_factor,
    output logic              ext_sel_q
);
    localparam int HI_W = CHAN_W - L1_W;

    arb_state_t state_q, state_d;

    logic tmr_edge, ext_fall;
    logic l1_pend, sw_pend, tm_pend;
    logic grant, grant_l1, grant_l2;
    logic [CHAN_W-1:0] chan_pick;

    pca_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b0), .DETECT_FALL(1'b0)) u_tmr_sync (
        .clk(clk), .rst_n(rst_n), .async_in(tmr_trig), .edge_pulse(tmr_edge)
    );

    pca_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1), .DETECT_FALL(1'b1)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_trig_pin), .edge_pulse(ext_fall)
    );

    pca_chan_mux #(.CHAN_W(CHAN_W), .L1_W(L1_W)) u_chan_mux (
        .use_l1(l1_pend), .use_pins(ext_sel_q), .l1_cfg(l1_chan_cfg),
        .pins(ext_chan_pins), .l2_cfg(l2_chan_cfg), .chan(chan_pick)
    );

    assign grant    = (state_q == ST_IDLE) && !conv_busy && (l1_pend || sw_pend || tm_pend);
    assign grant_l1 = grant && l1_pend;
    assign grant_l2 = grant && !l1_pend;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (grant) state_d = ST_LAUNCH;
            ST_LAUNCH:  state_d = ST_CONVERT;
            ST_CONVERT: if (!conv_busy) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture, grant payload and select bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l1_pend      <= 1'b0;
            sw_pend      <= 1'b0;
            tm_pend      <= 1'b0;
            start_chan   <= '0;
            start_factor <= '0;
            ext_sel_q    <= 1'b0;
        end else begin
            l1_pend <= (l1_pend && !grant_l1) || (ext_fall && ext_start_en);
            sw_pend <= (sw_pend && !grant_l2) || sw_start_wr;
            tm_pend <= (tm_pend && !grant_l2) || (tmr_edge && tmr_start_en);
            if (grant) begin
                start_chan   <= chan_pick;
                start_factor <= grant_l1 ? FAC_EXT : {1'b0, tm_pend, sw_pend};
            end
            if (sel_wr && state_q == ST_IDLE && !conv_busy) ext_sel_q <= sel_wdata;
        end
    end

    // outputs
    always_comb begin
        start_pulse = (state_q == ST_LAUNCH);
    end

    // ---------------- assertions ----------------
    assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_no_grant_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && conv_busy) |=> !start_pulse);

    assert_factor_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (start_factor == FAC_EXT) ||
                        (!start_factor[2] && start_factor[1:0] != 2'b00));

    assert_l1_chan_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && start_factor[2]) |-> (start_chan[CHAN_W-1:L1_W] == HI_W'(0)));

    assert_l1_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !conv_busy && l1_pend) |=> (start_pulse && start_factor == FAC_EXT));

    assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_IDLE) |-> $stable(ext_sel_q));
endmodule

// File: tb/prio_conv_arbiter_tb_top.sv
module prio_conv_arbiter_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_start_wr = 1'b0, tmr_trig = 1'b0, ext_trig_pin = 1'b1;
    logic ext_start_en = 1'b0, tmr_start_en = 1'b0, sel_wr = 1'b0, sel_wdata = 1'b0;
    logic [2:0] l1_chan_cfg = 3'd0, ext_chan_pins = 3'd0;
    logic [4:0] l2_chan_cfg = 5'd0;
    logic force_busy = 1'b0, conv_run = 1'b0;
    logic conv_busy;
    logic start_pulse, ext_sel_q;
    logic [4:0] start_chan;
    logic [2:0] start_factor;

    int total = 0, bad = 0, npulse = 0, bcnt = 0;
    logic [4:0] last_chan = 5'd0;
    logic [2:0] fq[$];

    // reference model state
    int   m_st = 0;
    bit   m_l1, m_sw, m_tm, m_sel;
    logic [4:0] m_chan;
    logic [2:0] m_fac;
    bit   tq[$], eq[$];

    always #4 clk = ~clk;

    assign conv_busy = conv_run || force_busy;

    prio_conv_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .sw_start_wr(sw_start_wr), .tmr_trig(tmr_trig),
        .ext_trig_pin(ext_trig_pin), .ext_start_en(ext_start_en), .tmr_start_en(tmr_start_en),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .l1_chan_cfg(l1_chan_cfg),
        .l2_chan_cfg(l2_chan_cfg), .ext_chan_pins(ext_chan_pins), .conv_busy(conv_busy),
        .start_pulse(start_pulse), .start_chan(start_chan), .start_factor(start_factor),
        .ext_sel_q(ext_sel_q)
    );

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // behavioural model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_l1 = 0; m_sw = 0; m_tm = 0; m_sel = 0;
            m_chan = 0; m_fac = 0;
            tq = '{0, 0, 0};
            eq = '{1, 1, 1};
        end else begin
            int  old_st;
            bit  t_rise, e_fall, gr, g1, g2;
            old_st = m_st;
            t_rise = tq[1] && !tq[2];
            e_fall = !eq[1] && eq[2];
            gr = (old_st == 0) && !conv_busy && (m_l1 || m_sw || m_tm);
            g1 = gr && m_l1;
            g2 = gr && !m_l1;
            if (g1) begin
                m_fac  = 3'b100;
                m_chan = {2'b00, (m_sel ? ext_chan_pins : l1_chan_cfg)};
            end else if (g2) begin
                m_fac  = {1'b0, m_tm, m_sw};
                m_chan = l2_chan_cfg;
            end
            if (sel_wr && old_st == 0 && !conv_busy) m_sel = sel_wdata;
            m_l1 = (m_l1 && !g1) || (e_fall && ext_start_en);
            m_sw = (m_sw && !g2) || sw_start_wr;
            m_tm = (m_tm && !g2) || (t_rise && tmr_start_en);
            if (gr)                               m_st = 1;
            else if (old_st == 1)                 m_st = 2;
            else if (old_st == 2 && !conv_busy)   m_st = 0;
            tq.push_front(tmr_trig); void'(tq.pop_back());
            eq.push_front(ext_trig_pin); void'(eq.pop_back());
        end
    end

    // converter stand-in, per-clock comparison and pulse monitor
    always @(negedge clk) begin
        if (bcnt > 0) bcnt--;
        if (start_pulse) bcnt = 5;
        conv_run = (bcnt > 0);
        if (rst_n) begin
            chk("R1 pulse vs model", int'(start_pulse), int'(m_st == 1));
            chk("R7/R8 chan vs model", int'(start_chan), int'(m_chan));
            chk("R2/R3/R4/R5 factor vs model", int'(start_factor), int'(m_fac));
            chk("R9 select bit vs model", int'(ext_sel_q), int'(m_sel));
            if (start_pulse) begin
                npulse++;
                fq.push_back(start_factor);
                last_chan = start_chan;
            end
        end
    end

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0;
        step(3);
        // R11 reset state
        chk("R11 pulse at reset", int'(start_pulse), 0);
        chk("R11 chan at reset", int'(start_chan), 0);
        chk("R11 factor at reset", int'(start_factor), 0);
        chk("R11 select at reset", int'(ext_sel_q), 0);
        rst_n = 1'b1;
        step(4);
        chk("R11 no pending after reset", npulse, 0);

        // R4 software start with timer disabled, R7 channel, R10 latency
        l2_chan_cfg = 5'd19;
        sw_start_wr = 1'b1; step(); sw_start_wr = 1'b0;
        chk("R10 sw latency early", int'(start_pulse), 0);
        step();
        chk("R10 sw latency exact", int'(start_pulse), 1);
        step(12);
        chk("R4 sw factor", int'(fq[$]), 1);
        chk("R7 l2 channel", int'(last_chan), 19);

        // R3 timer disabled then enabled
        n0 = npulse;
        tmr_trig = 1'b1; step(8); tmr_trig = 1'b0; step(8);
        chk("R3 timer disabled", npulse, n0);
        tmr_start_en = 1'b1; l2_chan_cfg = 5'd31;
        tmr_trig = 1'b1; step(15); tmr_trig = 1'b0; step(5);
        chk("R3 timer count", npulse, n0 + 1);
        chk("R3 timer factor", int'(fq[$]), 2);
        chk("R7 l2 channel 31", int'(last_chan), 31);

        // R5 software and timer together
        n0 = npulse;
        tmr_trig = 1'b1; step(); step();
        sw_start_wr = 1'b1; step(); sw_start_wr = 1'b0;
        step(15); tmr_trig = 1'b0; step(3);
        chk("R5 merged count", npulse, n0 + 1);
        chk("R5 merged factor", int'(fq[$]), 3);
        tmr_start_en = 1'b0;

        // R2 external falling edge, R8 register channel, R10 latency
        ext_start_en = 1'b1; l1_chan_cfg = 3'd5; ext_chan_pins = 3'd2;
        n0 = npulse;
        ext_trig_pin = 1'b0;
        step(3);
        chk("R10 ext latency early", int'(start_pulse), 0);
        step();
        chk("R10 ext latency exact", int'(start_pulse), 1);
        step(12);
        chk("R2 ext factor", int'(fq[$]), 4);
        chk("R8 l1 chan from field", int'(last_chan), 5);
        ext_trig_pin = 1'b1; step(12);
        chk("R2 rising edge ignored", npulse, n0 + 1);
        ext_start_en = 1'b0;
        ext_trig_pin = 1'b0; step(8); ext_trig_pin = 1'b1; step(8);
        chk("R2 disabled fall ignored", npulse, n0 + 1);

        // R8 pins as channel source
        sel_wdata = 1'b1; sel_wr = 1'b1; step(); sel_wr = 1'b0;
        chk("R9 idle write taken", int'(ext_sel_q), 1);
        ext_start_en = 1'b1; ext_chan_pins = 3'd6;
        ext_trig_pin = 1'b0; step(4);
        chk("R8 pin source pulse", int'(start_pulse), 1);
        chk("R8 l1 chan from pins", int'(start_chan), 6);
        // R9 write during the conversion is refused
        step();
        sel_wdata = 1'b0; sel_wr = 1'b1; step(); sel_wr = 1'b0;
        chk("R9 busy write ignored", int'(ext_sel_q), 1);
        ext_trig_pin = 1'b1; step(12);
        sel_wr = 1'b1; step(); sel_wr = 1'b0;
        chk("R9 later idle write", int'(ext_sel_q), 0);

        // R6 level-1 ahead of pending level-2, R1 no grant under busy
        fq.delete();
        n0 = npulse;
        force_busy = 1'b1;
        sw_start_wr = 1'b1; step(); sw_start_wr = 1'b0;
        ext_trig_pin = 1'b0; step(10);
        chk("R1 held while busy", npulse, n0);
        force_busy = 1'b0;
        step(25);
        chk("R6 both granted", npulse, n0 + 2);
        chk("R6 first is level 1", int'(fq[0]), 4);
        chk("R6 level 2 kept", int'(fq[1]), 1);
        ext_trig_pin = 1'b1; step(5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule